// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause 22 management master for an Ethernet PHY, controlled through one 32-bit command/status register. Software writes the frame fields and the write data into the register with the go bit (bit 31) clear. It then writes the same value again with bit 31 set. That second write launches a serial frame on the management clock and data pins. Bit 31 reads back as a busy flag, and the block clears it when the frame ends. After a read frame, the low half of the same register holds the 16 bits captured from the PHY.

The management clock (MDC) comes from the system clock through a divider. Its half period is `HALF_DIV` system clocks, and it runs only while a frame is in flight. The data pin is split into `mdio_o`, `mdio_oe` and `mdio_i`, so the pad's tri-state buffer stays outside the block. A frame is 64 MDC periods long. The master shifts out a new bit after each falling edge of MDC and samples read data on each rising edge.

The frame engine is a five-state machine. `ST_IDLE` goes to `ST_PRE` on a start. `ST_PRE` lasts for bits 0 to 31 and goes to `ST_HDR`. `ST_HDR` lasts for bits 32 to 45 and goes to `ST_TA`. `ST_TA` lasts for bits 46 and 47 and goes to `ST_DAT`. `ST_DAT` lasts for bits 48 to 63 and returns to `ST_IDLE`. Each transition is taken on the falling MDC edge that ends the last bit of its phase.

Top module: `mdio_master`

## Requirements
- R1: After reset, `reg_rdata` reads 0, `mdc` is 0 and `mdio_oe` is 0.
- R2: A frame starts only on a cycle with `reg_wr`=1, `reg_wdata[31]`=1 and busy=0. A write with bit 31 clear stores bits 29:16 (read back in `reg_rdata[29:16]`) and starts nothing.
- R3: `reg_rdata[31]` reads 1 for exactly 64 MDC periods (128·`HALF_DIV` system clocks) from the start, then reads 0. While busy is 0, both `mdc` and `mdio_oe` are 0.
- R4: While busy, `mdc` toggles every `HALF_DIV` system clocks. It starts low, and its first edge is a rising edge.
- R5: The bits seen at the rising edges of `mdc` are as follows. First come 32 ones. Then come the start code `[17:16]`, the opcode `[19:18]`, the PHY address `[24:20]` and the register address `[29:25]`, each field sent MSB first.
- R6: When the opcode is anything other than 10, the master drives bits 46 to 47 as 1 then 0, followed by `[15:0]` MSB first, with `mdio_oe`=1 for all 64 bits.
- R7: When the opcode is 10 (read), `mdio_oe` is 0 for bits 46 to 63. `mdio_i` is sampled at the rising edges of bits 48 to 63, MSB first, and the 16-bit result is read back in `reg_rdata[15:0]` once busy is 0.
- R8: While driven, `mdio_o` changes only in the cycle after a falling edge of `mdc`.
- R9: Register writes while busy is 1 are ignored. They do not change the frame in flight or the stored fields, and they start no second frame.
- R10: `reg_rdata[15:0]` keeps the last captured read value until the next read completes. The write data of a write frame never shows there. Bit 30 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Busy flag, stored fields, last read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data out to the pad |
| mdio_oe | output | 1 | Data pad output enable |
| mdio_i | input | 1 | Data in from the pad |

## Verification
The bound checker checks several rules on every cycle. A rise of busy must follow a go write. MDC and the output enable must be quiet while idle. The driven data bit may change only right after an MDC fall. The stored fields must not move during a frame, and the read-data half must not move while idle. The bench's scenarios cover what those per-cycle rules cannot show: the exact 64-bit serial image of each frame, the turnaround and release pattern for reads against writes, the MDC half period, the frame length, and the data captured from a modelled PHY.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_BITS    = 2;
    localparam int DAT_BITS   = 16;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DAT_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int PRE_LAST   = PRE_BITS - 1;
    localparam int HDR_LAST   = PRE_LAST + HDR_BITS;
    localparam int TA_LAST    = HDR_LAST + TA_BITS;
    localparam int DAT_LAST   = FRAME_BITS - 1;
    localparam logic [1:0] OPC_READ = 2'b10;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DAT
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tk,
    output logic fall_tk
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap    = run && (cnt_q == CNT_LAST);
    assign rise_tk = wrap && !mdc;
    assign fall_tk = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  frame_rd,
    input  logic                  rise_tk,
    input  logic                  fall_tk,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [DAT_BITS-1:0]   cap_data,
    output logic                  rd_done
);
    mdio_state_e           state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  rd_q;
    logic                  bit_end;

    assign bit_end = fall_tk && (state_q != ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PRE;
            ST_PRE:  if (bit_end && idx_q == IDX_W'(PRE_LAST)) state_d = ST_HDR;
            ST_HDR:  if (bit_end && idx_q == IDX_W'(HDR_LAST)) state_d = ST_TA;
            ST_TA:   if (bit_end && idx_q == IDX_W'(TA_LAST))  state_d = ST_DAT;
            ST_DAT:  if (bit_end && idx_q == IDX_W'(DAT_LAST)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, bit index and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            idx_q    <= '0;
            rd_q     <= 1'b0;
            cap_data <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                sh_q  <= frame;
                idx_q <= '0;
                rd_q  <= frame_rd;
            end
        end else begin
            if (rise_tk && rd_q && state_q == ST_DAT)
                cap_data <= {cap_data[DAT_BITS-2:0], mdio_i};
            if (bit_end) begin
                sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        mdio_o  = busy && sh_q[FRAME_BITS-1];
        mdio_oe = busy && !(rd_q && (state_q == ST_TA || state_q == ST_DAT));
        rd_done = (state_q == ST_DAT) && (state_d == ST_IDLE) && rd_q;
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [HDR_BITS-1:0]   fld_q;
    logic [DAT_BITS-1:0]   rdv_q;
    logic [DAT_BITS-1:0]   cap;
    logic                  busy, rd_done, start, rise_tk, fall_tk, is_rd;
    logic [FRAME_BITS-1:0] frame;
    logic [1:0]            w_st, w_op;
    logic [4:0]            w_phy, w_reg;

    assign w_st  = reg_wdata[17:16];
    assign w_op  = reg_wdata[19:18];
    assign w_phy = reg_wdata[24:20];
    assign w_reg = reg_wdata[29:25];
    assign is_rd = (w_op == OPC_READ);
    assign start = reg_wr && reg_wdata[31] && !busy;
    assign frame = {{PRE_BITS{1'b1}}, w_st, w_op, w_phy, w_reg,
                    (is_rd ? 2'b11 : TA_DRIVE),
                    (is_rd ? {DAT_BITS{1'b0}} : reg_wdata[DAT_BITS-1:0])};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
            rdv_q <= '0;
        end else begin
            if (reg_wr && !busy) fld_q <= reg_wdata[29:16];
            if (rd_done)         rdv_q <= cap;
        end
    end

    assign reg_rdata = {busy, 1'b0, fld_q, rdv_q};

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .mdc     (mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (frame),
        .frame_rd (is_rd),
        .rise_tk  (rise_tk),
        .fall_tk  (fall_tk),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .cap_data (cap),
        .rd_done  (rd_done)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R2: busy rises only after a go write
    p_start_on_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[31]) |-> $past(reg_wr && reg_wdata[31]));

    // R3: idle means clock low and pad released
    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> (!mdc && !mdio_oe));

    // R8: driven data moves only right after an MDC fall
    p_change_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

    // R9: stored fields frozen during a frame
    p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && $past(reg_rdata[31])) |-> $stable(reg_rdata[30:16]));

    // R10: read data holds while idle
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && !$past(reg_rdata[31])) |-> $stable(reg_rdata[15:0]));
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 4;

    typedef struct packed {
        logic [63:0] bits;
        logic [63:0] oe;
    } frm_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int n_frames = 0;
    frm_t exp_q[$];
    logic [15:0] phy_pat = '0;
    logic [15:0] last_rd = '0;

    always #2 clk = !clk;

    mdio_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: frame image at MDC rises, half period, edge placement
    logic        prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b0;
    int          bit_n = 0, run_len = 0;
    logic        bad_edge = 1'b0, bad_half = 1'b0;
    logic [63:0] obs_b = '0, obs_oe = '0;
    always @(negedge clk) begin
        if (mdio_oe && prev_oe && mdio_o != prev_o && !(prev_mdc && !mdc))
            bad_edge = 1'b1;
        if (mdc != prev_mdc) begin
            if (bit_n > 0 && run_len != HALF) bad_half = 1'b1;
            run_len = 1;
        end else begin
            run_len++;
        end
        if (mdc && !prev_mdc) begin
            obs_b[63-bit_n]  = mdio_o;
            obs_oe[63-bit_n] = mdio_oe;
            if (bit_n + 1 >= 48 && bit_n + 1 <= 63) mdio_i = phy_pat[63-(bit_n+1)];
            else                                    mdio_i = 1'b1;
            bit_n++;
            if (bit_n == 64) begin
                frm_t e;
                n_frames++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected frame", obs_b, 64'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(obs_oe == e.oe, "R6/R7 oe profile", obs_oe, e.oe);
                    chk((obs_b & e.oe) == (e.bits & e.oe), "R5/R6 frame bits",
                        obs_b & e.oe, e.bits & e.oe);
                end
                chk(!bad_edge, "R8 data edge after MDC fall", 64'(bad_edge), 64'h0);
                chk(!bad_half, "R4 MDC half period", 64'(bad_half), 64'h0);
                bad_edge = 1'b0;
                bad_half = 1'b0;
                bit_n = 0;
                mdio_i = 1'b1;
            end
        end
        prev_mdc = mdc;
        prev_oe  = mdio_oe;
        prev_o   = mdio_o;
    end

    task automatic wr_reg(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // driver: pushes expected frame, issues command, checks completion
    task automatic do_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd, input logic [15:0] pat);
        logic [1:0]  op = rd ? 2'b10 : 2'b01;
        logic [31:0] v  = {2'b00, rg, phy, op, 2'b01, wd};
        frm_t e;
        int   busy_cyc = 0;
        e.bits = {32'hFFFF_FFFF, 2'b01, op, phy, rg, (rd ? 2'b11 : 2'b10),
                  (rd ? 16'h0 : wd)};
        e.oe   = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        exp_q.push_back(e);
        phy_pat = pat;
        wr_reg(v);
        chk(reg_rdata[31] == 1'b0, "R2 no start without go", 64'(reg_rdata[31]), 64'h0);
        reg_wr = 1'b1;
        reg_wdata = v | 32'h8000_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        while (reg_rdata[31] && busy_cyc < 5000) begin
            busy_cyc++;
            @(negedge clk);
        end
        chk(busy_cyc == 128*HALF, "R3 busy length", 64'(busy_cyc), 64'(128*HALF));
        if (rd) last_rd = pat;
        chk(reg_rdata[15:0] == last_rd, rd ? "R7 read data" : "R10 read data kept",
            64'(reg_rdata[15:0]), 64'(last_rd));
        chk(reg_rdata[30:16] == v[30:16], "R10 fields readback",
            64'(reg_rdata[30:16]), 64'(v[30:16]));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(reg_rdata == 32'h0 && !mdc && !mdio_oe, "R1 reset state",
            64'(reg_rdata), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: fields stored, no frame without go bit
        wr_reg(32'h3FFF_1234);
        repeat (20) @(negedge clk);
        chk(reg_rdata == 32'h3FFF_0000, "R2 store without start", 64'(reg_rdata),
            64'h3FFF_0000);
        chk(n_frames == 0 && !mdc, "R2 no frame", 64'(n_frames), 64'h0);

        do_cmd(1'b0, 5'd5, 5'd3, 16'hA5C3, 16'h0);
        do_cmd(1'b1, 5'd1, 5'd2, 16'h0, 16'h1234);
        do_cmd(1'b0, 5'd0, 5'd0, 16'hFFFF, 16'h0);
        do_cmd(1'b1, 5'd31, 5'd31, 16'h0, 16'h8001);
        do_cmd(1'b1, 5'd16, 5'd1, 16'h0, 16'hFFFF);

        // R9: go write during a frame is ignored
        begin
            frm_t e;
            e.bits = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd7, 5'd9, 2'b10, 16'h0F0F};
            e.oe   = {64{1'b1}};
            exp_q.push_back(e);
            wr_reg({2'b10, 5'd9, 5'd7, 2'b01, 2'b01, 16'h0F0F});
            repeat (100) @(negedge clk);
            wr_reg(32'hFFFF_FFFF);
            wr_reg(32'h0000_0000);
            while (reg_rdata[31]) @(negedge clk);
            chk(reg_rdata[30:16] == {1'b0, 5'd9, 5'd7, 2'b01, 2'b01}, "R9 fields unchanged",
                64'(reg_rdata[30:16]), 64'({1'b0, 5'd9, 5'd7, 2'b01, 2'b01}));
            chk(reg_rdata[15:0] == last_rd, "R10 read data kept after write",
                64'(reg_rdata[15:0]), 64'(last_rd));
            repeat (200) @(negedge clk);
            chk(n_frames == 6 && exp_q.size() == 0, "R9 single frame", 64'(n_frames),
                64'd6);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule